// File: doc/BRIEF.md
# Polled Console Keyboard and Display Port

This block is a peripheral with no interrupts. It gives a 16-bit processor bus four word registers in an eight-byte window at the top of the address space. A keyboard delivers characters to it, and it sends characters out to a display. The processor learns whether either device is ready only by reading a status word. Readiness appears in bit 15 alone, so a signed load of a status word is negative exactly when its device is ready.

The keyboard side is a valid-only stream. A code is taken on every cycle that `kbd_valid` is high, and there is no back-pressure: a newer code replaces an unread one. The display side is a one-cycle `disp_valid` strobe. The display pushes back by holding off `disp_done`, and the processor sees that wait as a clear display-ready bit. The bus is a plain single-cycle port. Read data is combinational for the cycle in which `bus_rd` is high, and a write takes effect on the clock edge that ends the cycle in which `bus_wr` is high.

Top module: `console_io_unit`

## Requirements
- R1: Register offsets from 0xFE00 are fixed: keyboard status at 0xFE00, keyboard data at 0xFE02, display status at 0xFE04 and display data at 0xFE06. `bus_rdata` shows the addressed word in the same cycle that `bus_rd` is high, and is 0x0000 while `bus_rd` is low.
- R2: A read of either status word returns the ready flag in bit 15 and zero in bits 14..0.
- R3: On the edge that ends a cycle with `kbd_valid` high, the keyboard data word becomes {8'h00, `kbd_code`} and keyboard status bit 15 becomes 1.
- R4: A read of the keyboard data word with no key arriving in that cycle clears keyboard status bit 15 at the next edge and leaves the data word unchanged.
- R5: A key that arrives while keyboard status bit 15 is set overwrites the data word and leaves bit 15 set. If a key arrives in the same cycle as a keyboard data read, the key wins and bit 15 stays 1.
- R6: A write to 0xFE06 makes `disp_valid` high for exactly the next cycle with `disp_char` = `bus_wdata[7:0]`. It clears display status bit 15, and a read of 0xFE06 then returns {8'h00, char}.
- R7: When `disp_done` is high, display status bit 15 returns to 1 at the next edge. If a display data write falls in the same cycle, the write wins and bit 15 is 0.
- R8: Writes to 0xFE00, 0xFE02 and 0xFE04 change no readable state.
- R9: Reads of 0xFE01, 0xFE03, 0xFE05, 0xFE07 and of any address outside the window return 0x0000.
- R10: Synchronous active-high reset leaves keyboard status bit 15 at 0, display status bit 15 at 1, both data words at 0 and `disp_valid` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Byte address of the bus access |
| bus_rd | input | 1 | Read in this cycle |
| bus_wr | input | 1 | Write in this cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |
| kbd_valid | input | 1 | Keyboard code present this cycle |
| kbd_code | input | 8 | ASCII code from the keyboard |
| disp_valid | output | 1 | One-cycle character strobe to the display |
| disp_char | output | 8 | Character for the display |
| disp_done | input | 1 | Display has finished the last character |

## Verification
Two pairs of events can land in the same cycle. A key can arrive during a read of the keyboard data word, and `disp_done` can rise during a write of the display data word. Directed steps force each pair into one cycle, and the random phase drives key arrivals and done pulses independently of the bus traffic, so both pairs recur many times. In each case a reference model in the bench decides the winner from R5 and R7, and the next status read must match it.

// File: rtl/console_io_pkg.sv
`timescale 1ns/1ps
package console_io_pkg;
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_KSTAT,
    SEL_KDATA,
    SEL_DSTAT,
    SEL_DDATA
  } reg_sel_e;

  localparam int WIN_LSB = 3;
  localparam logic [2:0] OFS_KSTAT = 3'd0;
  localparam logic [2:0] OFS_KDATA = 3'd2;
  localparam logic [2:0] OFS_DSTAT = 3'd4;
  localparam logic [2:0] OFS_DDATA = 3'd6;
endpackage

// File: rtl/console_addr_decode.sv
`timescale 1ns/1ps
module console_addr_decode
  import console_io_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE = 16'hFE00
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  localparam logic [ADDR_W-WIN_LSB-1:0] WIN_TAG = BASE[ADDR_W-1:WIN_LSB];

  always_comb begin
    sel = SEL_NONE;
    if (addr[ADDR_W-1:WIN_LSB] == WIN_TAG) begin
      case (addr[WIN_LSB-1:0])
        OFS_KSTAT: sel = SEL_KSTAT;
        OFS_KDATA: sel = SEL_KDATA;
        OFS_DSTAT: sel = SEL_DSTAT;
        OFS_DDATA: sel = SEL_DDATA;
        default:   sel = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/console_kbd_port.sv
`timescale 1ns/1ps
module console_kbd_port #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              key_valid,
  input  logic [CHAR_W-1:0] key_code,
  input  logic              take,
  output logic              full,
  output logic [CHAR_W-1:0] data
);
  // A new key always wins over a consuming read in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      data <= '0;
    end else if (key_valid) begin
      full <= 1'b1;
      data <= key_code;
    end else if (take) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/console_disp_port.sv
`timescale 1ns/1ps
module console_disp_port #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CHAR_W-1:0] load_char,
  input  logic              done,
  output logic              ready,
  output logic              out_valid,
  output logic [CHAR_W-1:0] out_char
);
  // A write in the same cycle as done leaves the port busy.
  always_ff @(posedge clk) begin
    if (rst) begin
      ready     <= 1'b1;
      out_valid <= 1'b0;
      out_char  <= '0;
    end else begin
      out_valid <= load;
      if (load) begin
        ready    <= 1'b0;
        out_char <= load_char;
      end else if (done) begin
        ready <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/console_io_unit.sv
`timescale 1ns/1ps
module console_io_unit
  import console_io_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CHAR_W = 8,
  parameter logic [ADDR_W-1:0] BASE = 16'hFE00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              kbd_valid,
  input  logic [CHAR_W-1:0] kbd_code,
  output logic              disp_valid,
  output logic [CHAR_W-1:0] disp_char,
  input  logic              disp_done
);
  localparam int PAD_W  = DATA_W - CHAR_W;
  localparam int FLAG_W = DATA_W - 1;

  reg_sel_e          sel;
  logic              kbd_full;
  logic [CHAR_W-1:0] kbd_data;
  logic              dsp_ready;

  console_addr_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
    .addr(bus_addr),
    .sel (sel)
  );

  console_kbd_port #(.CHAR_W(CHAR_W)) u_kbd (
    .clk      (clk),
    .rst      (rst),
    .key_valid(kbd_valid),
    .key_code (kbd_code),
    .take     (bus_rd && (sel == SEL_KDATA)),
    .full     (kbd_full),
    .data     (kbd_data)
  );

  console_disp_port #(.CHAR_W(CHAR_W)) u_dsp (
    .clk      (clk),
    .rst      (rst),
    .load     (bus_wr && (sel == SEL_DDATA)),
    .load_char(bus_wdata[CHAR_W-1:0]),
    .done     (disp_done),
    .ready    (dsp_ready),
    .out_valid(disp_valid),
    .out_char (disp_char)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (sel)
        SEL_KSTAT: bus_rdata = {kbd_full, {FLAG_W{1'b0}}};
        SEL_KDATA: bus_rdata = {{PAD_W{1'b0}}, kbd_data};
        SEL_DSTAT: bus_rdata = {dsp_ready, {FLAG_W{1'b0}}};
        SEL_DDATA: bus_rdata = {{PAD_W{1'b0}}, disp_char};
        default:   bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/console_io_checker.sv
`timescale 1ns/1ps
module console_io_checker (
  input logic        clk,
  input logic        rst,
  input logic [15:0] bus_addr,
  input logic        bus_rd,
  input logic        bus_wr,
  input logic [15:0] bus_wdata,
  input logic [15:0] bus_rdata,
  input logic        kbd_valid,
  input logic [7:0]  kbd_code,
  input logic        disp_valid,
  input logic [7:0]  disp_char,
  input logic        disp_done,
  input logic        kbd_full,
  input logic [7:0]  kbd_data,
  input logic        dsp_ready
);
  logic ddr_wr, kdr_rd, kdr_wr, stat_rd;
  assign ddr_wr  = bus_wr && (bus_addr == 16'hFE06);
  assign kdr_rd  = bus_rd && (bus_addr == 16'hFE02);
  assign kdr_wr  = bus_wr && (bus_addr == 16'hFE02);
  assign stat_rd = bus_rd && ((bus_addr == 16'hFE00) || (bus_addr == 16'hFE04));

  // R2
  status_bits_chk: assert property (@(posedge clk) disable iff (rst)
    stat_rd |-> (bus_rdata[14:0] == 15'd0));

  // R3
  key_load_chk: assert property (@(posedge clk) disable iff (rst)
    kbd_valid |=> (kbd_full && (kbd_data == $past(kbd_code))));

  // R4
  key_take_chk: assert property (@(posedge clk) disable iff (rst)
    (kdr_rd && !kbd_valid) |=> (!kbd_full && $stable(kbd_data)));

  // R6
  ddr_launch_chk: assert property (@(posedge clk) disable iff (rst)
    ddr_wr |=> (disp_valid && !dsp_ready && (disp_char == $past(bus_wdata[7:0]))));

  // R6
  strobe_origin_chk: assert property (@(posedge clk) disable iff (rst)
    (disp_valid && !$past(rst)) |-> $past(ddr_wr));

  // R7
  done_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (disp_done && !ddr_wr) |=> dsp_ready);

  // R8
  kdata_ro_chk: assert property (@(posedge clk) disable iff (rst)
    (kdr_wr && !kbd_valid) |=> $stable(kbd_data));
endmodule

bind console_io_unit console_io_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .kbd_valid (kbd_valid),
  .kbd_code  (kbd_code),
  .disp_valid(disp_valid),
  .disp_char (disp_char),
  .disp_done (disp_done),
  .kbd_full  (kbd_full),
  .kbd_data  (kbd_data),
  .dsp_ready (dsp_ready)
);

// File: tb/tb_console_io_unit.sv
`timescale 1ns/1ps
module tb_console_io_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        kbd_valid = 1'b0;
  logic [7:0]  kbd_code = '0;
  logic        disp_valid;
  logic [7:0]  disp_char;
  logic        disp_done = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // reference model
  bit       m_kfull, m_dready, m_dvalid;
  bit [7:0] m_kdata, m_dchar;

  always #2.5 clk = ~clk;

  console_io_unit dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .kbd_valid(kbd_valid),
    .kbd_code(kbd_code), .disp_valid(disp_valid), .disp_char(disp_char),
    .disp_done(disp_done)
  );

  function automatic logic [15:0] exp_read(input logic rd, input logic [15:0] a);
    if (!rd) return 16'h0000;
    case (a)
      16'hFE00: return {m_kfull, 15'd0};
      16'hFE02: return {8'h00, m_kdata};
      16'hFE04: return {m_dready, 15'd0};
      16'hFE06: return {8'h00, m_dchar};
      default:  return 16'h0000;
    endcase
  endfunction

  function automatic string tag_of(input logic rd, input logic [15:0] a);
    if (!rd) return "R1";
    case (a)
      16'hFE00, 16'hFE04: return "R2";
      16'hFE02: return "R3";
      16'hFE06: return "R6";
      default:  return "R9";
    endcase
  endfunction

  task automatic check(input string tg, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tg, act, exp, $time);
    end
  endtask

  task automatic step(input logic rd, input logic wr, input logic [15:0] a,
                      input logic [15:0] wd, input logic kv, input logic [7:0] kc,
                      input logic dn, input string tg);
    bit ddr_wr, kdr_rd;
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    kbd_valid = kv; kbd_code = kc; disp_done = dn;
    #1;
    check((tg == "") ? tag_of(rd, a) : tg, bus_rdata, exp_read(rd, a));
    check("R6", {15'd0, disp_valid}, {15'd0, m_dvalid});
    if (m_dvalid) check("R6", {8'h00, disp_char}, {8'h00, m_dchar});
    ddr_wr = wr && (a == 16'hFE06);
    kdr_rd = rd && (a == 16'hFE02);
    if (kv) begin m_kfull = 1; m_kdata = kc; end
    else if (kdr_rd) m_kfull = 0;
    if (ddr_wr) begin m_dready = 0; m_dchar = wd[7:0]; m_dvalid = 1; end
    else begin m_dvalid = 0; if (dn) m_dready = 1; end
  endtask

  task automatic rd_reg(input logic [15:0] a, input string tg);
    step(1, 0, a, 16'h0, 0, 8'h0, 0, tg);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_kfull = 0; m_dready = 1; m_dvalid = 0; m_kdata = 0; m_dchar = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R10 reset state
    rd_reg(16'hFE00, "R10");
    rd_reg(16'hFE02, "R10");
    rd_reg(16'hFE04, "R10");
    rd_reg(16'hFE06, "R10");
    // R1 read strobe low gives zero
    step(0, 0, 16'hFE04, 0, 0, 0, 0, "R1");
    // R3 key arrival, then R4 consume
    step(0, 0, 16'h0000, 0, 1, 8'h41, 0, "R3");
    rd_reg(16'hFE00, "R3");
    rd_reg(16'hFE02, "R4");
    rd_reg(16'hFE00, "R4");
    rd_reg(16'hFE02, "R4");
    // R5 overwrite while full
    step(0, 0, 16'h0000, 0, 1, 8'h62, 0, "R5");
    step(0, 0, 16'h0000, 0, 1, 8'h63, 0, "R5");
    rd_reg(16'hFE00, "R5");
    // R5 key in same cycle as data read: key wins
    step(1, 0, 16'hFE02, 0, 1, 8'h64, 0, "R5");
    rd_reg(16'hFE00, "R5");
    rd_reg(16'hFE02, "R5");
    // R8 writes to read-only words
    step(0, 1, 16'hFE00, 16'h0000, 0, 0, 0, "R8");
    step(0, 1, 16'hFE02, 16'h0055, 0, 0, 0, "R8");
    step(0, 1, 16'hFE04, 16'h0000, 0, 0, 0, "R8");
    rd_reg(16'hFE00, "R8");
    rd_reg(16'hFE02, "R8");
    rd_reg(16'hFE04, "R8");
    // R6 display write
    step(0, 1, 16'hFE06, 16'hAB5A, 0, 0, 0, "R6");
    rd_reg(16'hFE04, "R6");
    rd_reg(16'hFE06, "R6");
    // R7 done returns ready
    step(0, 0, 16'h0000, 0, 0, 0, 1, "R7");
    rd_reg(16'hFE04, "R7");
    // R7 write and done same cycle: write wins
    step(0, 1, 16'hFE06, 16'h0031, 0, 0, 1, "R7");
    rd_reg(16'hFE04, "R7");
    // R9 unmapped
    rd_reg(16'hFE01, "R9");
    rd_reg(16'hFE07, "R9");
    rd_reg(16'hFE08, "R9");
    rd_reg(16'h3000, "R9");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int op;
      logic [15:0] a;
      op = $urandom % 6;
      a = 16'hFE00 | 16'($urandom % 8);
      case (op)
        0, 1: step(1, 0, a & 16'hFFFE, 0, ($urandom % 4) == 0, 8'($urandom), ($urandom % 3) == 0, "");
        2:    step(0, 1, a & 16'hFFFE, 16'($urandom), ($urandom % 4) == 0, 8'($urandom), ($urandom % 3) == 0, "");
        3:    step(1, 0, (($urandom % 2) == 0) ? a : 16'($urandom), 0, 0, 0, ($urandom % 3) == 0, "");
        4:    step(0, 0, a, 0, ($urandom % 3) == 0, 8'($urandom), ($urandom % 3) == 0, "");
        default: step(0, 0, a, 0, 0, 0, 0, "R1");
      endcase
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule